// File: doc/BRIEF.md
# Triangle-Carrier PWM with Carrier-Locked Triggers

This block generates a single pulse-width-modulated switch signal from an up-down counter that sweeps from zero to a programmed period and back again. The switch output is high while the carrier sits below the active compare value. New duty commands go into a shadow register and reach the active compare only at a carrier event chosen by configuration. Reloading at the carrier minimum gives trailing-edge-first symmetric modulation: the output falls on the rising slope and rises again on the falling slope. Reloading at the carrier peak gives the leading-edge-first ordering, with the new value in force from the peak onward. The period input is also shadowed and is taken only at the carrier minimum.

Two independent pulse outputs, one to start a converter sample and one to start a control task, fire on carrier events. Each has its own source selection (minimum, peak, or both) and its own integer decimator. Because the decimators are cleared at reset and advance only on the events they qualify, every trigger keeps a fixed phase against the carrier. This lets a control loop choose where in the switching cycle its measurement is taken and at what sub-rate.

Top module: `tri_pwm_gen`

## Requirements
- R1: The carrier counts 0, 1, ..., P, P-1, ..., 1 and then repeats, so one carrier cycle takes 2P clocks for an active period P of at least 1. The cycle in which the count is 0 is the minimum event. The cycle in which the count equals P while rising is the peak event.
- R2: The switch output is high when the carrier is below the active compare value. The active compare loads the shadow value at the minimum event when `load_at_peak` is 0, and at the peak event when it is 1. The new value is visible from the next clock.
- R3: An active compare of 0 holds the switch output low for the whole carrier cycle. An active compare at or above the active period holds it high for the whole carrier cycle.
- R4: Trigger source encoding is 2'b01 for the minimum, 2'b10 for the peak, 2'b11 for both and 2'b00 for off. A trigger pulse is asserted combinationally in the same clock as the qualifying event and lasts one clock.
- R5: A trigger divider of N passes the 1st, (N+1)th, (2N+1)th and later qualifying events, counted from reset. A divider of 0 acts as 1. With the peak source and N = 2, exactly one pulse occurs per two carrier peaks.
- R6: With source 2'b11 and divider 1, a trigger pulses twice per carrier cycle.
- R7: A cycle with `cmp_wr` high stores `cmp_in` in the shadow register, and the last write before a reload event wins. A write made in the reload cycle itself takes effect at the following reload. The active compare never changes between reload events.
- R8: After reset the carrier is at 0 and rising, both dividers are cleared and the active compare is 0. The switch output is therefore low, and the first clock after reset is a minimum event.
- R9: The sample trigger and the task trigger follow their own source and divider settings, and neither affects the other.
- R10: `per_in` is taken into the active period only at the minimum event. A change in mid-cycle leaves the current carrier cycle at its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| per_in | input | CW | Carrier period request, taken at the minimum event |
| cmp_in | input | CW | Duty compare value for the shadow register |
| cmp_wr | input | 1 | Write strobe for the compare shadow |
| load_at_peak | input | 1 | 0: reload compare at the minimum, 1: reload at the peak |
| adc_src | input | 2 | Sample trigger source select |
| adc_div | input | DW | Sample trigger decimation ratio |
| task_src | input | 2 | Task trigger source select |
| task_div | input | DW | Task trigger decimation ratio |
| pwm_out | output | 1 | Switch output |
| adc_trig | output | 1 | Sample-start pulse |
| task_trig | output | 1 | Task-start pulse |

## Verification
The bench targets the reload timing of both shadows. A compare that leaked through between events would show as a stray switch edge in mid-cycle. A period that leaked early would fold the carrier short and shorten the measured interval between minimum pulses. It drives the compare to 0, to the period and above the period, where an off-by-one compare would let a single-clock glitch through. It exercises decimation against peak-only, both-edge and zero-ratio settings: a divider that restarted at the wrong point or miscounted would change the pulse count in a fixed window, or drift its phase against the carrier.

// File: rtl/tri_pwm_pkg.sv
package tri_pwm_pkg;
   typedef enum logic [1:0] {
      SRC_OFF  = 2'b00,
      SRC_MIN  = 2'b01,
      SRC_PEAK = 2'b10,
      SRC_BOTH = 2'b11
   } trig_src_e;

   typedef struct packed {
      logic at_min;
      logic at_peak;
   } carrier_evt_t;
endpackage

// File: rtl/tri_pwm_carrier.sv
module tri_pwm_carrier #(
   parameter int CW = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [CW-1:0]              per_in,
   output logic [CW-1:0]              cnt_o,
   output logic                       rising_o,
   output logic [CW-1:0]              per_o,
   output tri_pwm_pkg::carrier_evt_t  evt_o
);
   logic [CW-1:0] cnt_q, per_q;
   logic          rising_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         per_q    <= '0;
         rising_q <= 1'b1;
      end else if (cnt_q == '0) begin
         per_q    <= per_in;
         rising_q <= 1'b1;
         cnt_q    <= (per_in == '0) ? '0 : CW'(1);
      end else if (rising_q) begin
         if (cnt_q >= per_q) begin
            rising_q <= 1'b0;
            cnt_q    <= cnt_q - 1'b1;
         end else begin
            cnt_q    <= cnt_q + 1'b1;
         end
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign cnt_o         = cnt_q;
   assign rising_o      = rising_q;
   assign per_o         = per_q;
   assign evt_o.at_min  = (cnt_q == '0);
   assign evt_o.at_peak = rising_q && (cnt_q == per_q) && (cnt_q != '0);
endmodule

// File: rtl/tri_pwm_compare.sv
module tri_pwm_compare #(
   parameter int CW = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [CW-1:0]              cmp_in,
   input  logic                       cmp_wr,
   input  logic                       load_at_peak,
   input  tri_pwm_pkg::carrier_evt_t  evt,
   input  logic [CW-1:0]              cnt,
   input  logic [CW-1:0]              per,
   output logic [CW-1:0]              cmp_act_o,
   output logic                       pwm_o
);
   logic [CW-1:0] shadow_q, act_q;
   logic          reload;

   assign reload = load_at_peak ? evt.at_peak : evt.at_min;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
         act_q    <= '0;
      end else begin
         if (cmp_wr) shadow_q <= cmp_in;
         if (reload) act_q    <= shadow_q;
      end
   end

   assign cmp_act_o = act_q;
   assign pwm_o     = (act_q != '0) && ((act_q >= per) || (cnt < act_q));
endmodule

// File: rtl/tri_pwm_trig.sv
module tri_pwm_trig #(
   parameter int DW = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  tri_pwm_pkg::trig_src_e     src,
   input  logic [DW-1:0]              div,
   input  tri_pwm_pkg::carrier_evt_t  evt,
   output logic                       trig_o
);
   logic [DW-1:0] ev_cnt_q;
   logic [DW:0]   ev_next;
   logic          qual, wrap;

   assign qual    = (src[0] && evt.at_min) || (src[1] && evt.at_peak);
   assign ev_next = {1'b0, ev_cnt_q} + 1'b1;
   assign wrap    = ev_next >= {1'b0, div};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ev_cnt_q <= '0;
      else if (qual) ev_cnt_q <= wrap ? '0 : ev_next[DW-1:0];
   end

   assign trig_o = qual && (ev_cnt_q == '0);
endmodule

// File: rtl/tri_pwm_gen.sv
module tri_pwm_gen #(
   parameter int CW = 16,
   parameter int DW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] per_in,
   input  logic [CW-1:0] cmp_in,
   input  logic          cmp_wr,
   input  logic          load_at_peak,
   input  logic [1:0]    adc_src,
   input  logic [DW-1:0] adc_div,
   input  logic [1:0]    task_src,
   input  logic [DW-1:0] task_div,
   output logic          pwm_out,
   output logic          adc_trig,
   output logic          task_trig
);
   import tri_pwm_pkg::*;

   localparam int NTRIG = 2;

   if (CW < 2) begin : g_bad_cw
      $error("tri_pwm_gen: CW must be at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("tri_pwm_gen: DW must be at least 1");
   end

   logic [CW-1:0] cnt, per_act, cmp_act;
   logic          dir_up;
   carrier_evt_t  evt;

   tri_pwm_carrier #(.CW(CW)) i_carrier (
      .clk(clk), .rst_n(rst_n), .per_in(per_in),
      .cnt_o(cnt), .rising_o(dir_up), .per_o(per_act), .evt_o(evt)
   );

   tri_pwm_compare #(.CW(CW)) i_compare (
      .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .cmp_wr(cmp_wr),
      .load_at_peak(load_at_peak), .evt(evt), .cnt(cnt), .per(per_act),
      .cmp_act_o(cmp_act), .pwm_o(pwm_out)
   );

   trig_src_e     src_a [NTRIG];
   logic [DW-1:0] div_a [NTRIG];
   logic          trig_a [NTRIG];

   assign src_a[0] = trig_src_e'(adc_src);
   assign src_a[1] = trig_src_e'(task_src);
   assign div_a[0] = adc_div;
   assign div_a[1] = task_div;

   for (genvar gi = 0; gi < NTRIG; gi++) begin : g_trig
      tri_pwm_trig #(.DW(DW)) i_trig (
         .clk(clk), .rst_n(rst_n), .src(src_a[gi]), .div(div_a[gi]),
         .evt(evt), .trig_o(trig_a[gi])
      );
   end

   assign adc_trig  = trig_a[0];
   assign task_trig = trig_a[1];
endmodule

// File: rtl/tri_pwm_chk.sv
module tri_pwm_chk #(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic [CW-1:0] cnt,
   input logic          dir_up,
   input logic [CW-1:0] per_act,
   input logic [CW-1:0] cmp_act,
   input logic          load_at_peak,
   input logic          pwm_out
);
   logic ev_min, ev_peak, ev_reload;
   assign ev_min    = (cnt == '0);
   assign ev_peak   = dir_up && (cnt == per_act) && (cnt != '0);
   assign ev_reload = load_at_peak ? ev_peak : ev_min;

   // R1: carrier never leaves the active range
   a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= per_act);

   // R1: a nonzero count moves by exactly one step
   a_r1_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |=> ((cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1)));

   // R7: active compare holds between reload events
   a_r7_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_reload |=> $stable(cmp_act));

   // R10: active period holds away from the minimum
   a_r10_per_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |=> $stable(per_act));

   // R3: zero compare keeps the switch low
   a_r3_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_act == '0) |-> !pwm_out);
endmodule

bind tri_pwm_gen tri_pwm_chk #(.CW(CW)) i_chk (
   .clk(clk), .rst_n(rst_n), .cnt(cnt), .dir_up(dir_up), .per_act(per_act),
   .cmp_act(cmp_act), .load_at_peak(load_at_peak), .pwm_out(pwm_out)
);

// File: tb/test_tri_pwm_gen.sv
module test_tri_pwm_gen;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 16;
   localparam int DW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] per_in = 16'd10;
   logic [CW-1:0] cmp_in = '0;
   logic          cmp_wr = 1'b0;
   logic          load_at_peak = 1'b0;
   logic [1:0]    adc_src = 2'b01;
   logic [DW-1:0] adc_div = 4'd1;
   logic [1:0]    task_src = 2'b10;
   logic [DW-1:0] task_div = 4'd1;
   logic          pwm_out, adc_trig, task_trig;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tri_pwm_gen #(.CW(CW), .DW(DW)) i_tri_pwm_gen (
      .clk(clk), .rst_n(rst_n), .per_in(per_in), .cmp_in(cmp_in), .cmp_wr(cmp_wr),
      .load_at_peak(load_at_peak), .adc_src(adc_src), .adc_div(adc_div),
      .task_src(task_src), .task_div(task_div),
      .pwm_out(pwm_out), .adc_trig(adc_trig), .task_trig(task_trig)
   );

   // behavioural reference
   int m_pos, m_len, m_cmp, m_shadow, m_ev_a, m_ev_t;
   bit m_up;

   function automatic bit m_min();  return m_pos == 0; endfunction
   function automatic bit m_peak(); return m_up && m_pos == m_len && m_pos != 0; endfunction
   function automatic bit m_qual(input logic [1:0] s);
      return (s[0] && m_min()) || (s[1] && m_peak());
   endfunction
   function automatic bit m_pwm();
      return m_cmp != 0 && (m_cmp >= m_len || m_pos < m_cmp);
   endfunction
   function automatic int m_step(input int cur, input int ratio);
      int r = (ratio < 1) ? 1 : ratio;
      return (cur + 1 >= r) ? 0 : cur + 1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pos = 0; m_len = 0; m_cmp = 0; m_shadow = 0; m_ev_a = 0; m_ev_t = 0; m_up = 1;
      end else begin
         bit rl, qa, qt;
         rl = load_at_peak ? m_peak() : m_min();
         qa = m_qual(adc_src);
         qt = m_qual(task_src);
         if (rl) m_cmp = m_shadow;
         if (cmp_wr) m_shadow = int'(cmp_in);
         if (qa) m_ev_a = m_step(m_ev_a, int'(adc_div));
         if (qt) m_ev_t = m_step(m_ev_t, int'(task_div));
         if (m_pos == 0) begin
            m_len = int'(per_in); m_up = 1;
            m_pos = (m_len == 0) ? 0 : 1;
         end else if (m_up) begin
            if (m_pos >= m_len) begin m_up = 0; m_pos = m_pos - 1; end
            else m_pos = m_pos + 1;
         end else m_pos = m_pos - 1;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         check("R2 pwm_out", int'(pwm_out), int'(m_pwm()));
         check("R4 adc_trig", int'(adc_trig), int'(m_qual(adc_src) && m_ev_a == 0));
         check("R4 task_trig", int'(task_trig), int'(m_qual(task_src) && m_ev_t == 0));
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic write_cmp(input int v);
      cmp_in = CW'(v); cmp_wr = 1'b1;
      tick(1);
      cmp_wr = 1'b0;
   endtask

   task automatic window(input int n, output int hi, output int na, output int nt);
      hi = 0; na = 0; nt = 0;
      repeat (n) begin
         @(negedge clk);
         hi += int'(pwm_out); na += int'(adc_trig); nt += int'(task_trig);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int hi, na, nt, gap;
      bit prev, dbl;
      tick(5);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 pwm low after reset", int'(pwm_out), 0);
      check("R8 first cycle is minimum event", int'(adc_trig), 1);
      check("R8 no peak trigger at reset", int'(task_trig), 0);

      // R1: minimum pulses every 2P clocks
      window(60, hi, na, nt);
      check("R1 minimum pulses in 60 clocks", na, 3);
      check("R1 peak pulses in 60 clocks", nt, 3);

      // R7: last write of several wins
      tick(1);
      write_cmp(3); write_cmp(7); write_cmp(5);
      tick(40);
      window(20, hi, na, nt);
      check("R7 last shadow write wins", hi, 9);

      // R2: reload at peak
      load_at_peak = 1'b1;
      write_cmp(2);
      tick(40);
      window(20, hi, na, nt);
      check("R2 peak reload duty", hi, 3);

      // R3: extremes
      write_cmp(0);
      tick(40);
      window(20, hi, na, nt);
      check("R3 zero compare low", hi, 0);
      write_cmp(10);
      tick(40);
      window(20, hi, na, nt);
      check("R3 compare equal to period high", hi, 20);
      write_cmp(15);
      tick(40);
      window(20, hi, na, nt);
      check("R3 compare above period high", hi, 20);

      // R5: peak source, divide by 2
      adc_src = 2'b10; adc_div = 4'd2;
      tick(40);
      window(160, hi, na, nt);
      check("R5 peak div2 over 8 periods", na, 4);
      adc_div = 4'd0;
      tick(40);
      window(80, hi, na, nt);
      check("R5 ratio 0 acts as 1", na, 4);

      // R6 and R9: both edges on task, div3 on sample trigger
      task_src = 2'b11; task_div = 4'd1;
      adc_src = 2'b10; adc_div = 4'd3;
      tick(80);
      window(120, hi, na, nt);
      check("R6 both edges twice per period", nt, 12);
      check("R9 sample trigger independent", na, 2);

      // R4: off source and one-clock width
      task_src = 2'b00;
      tick(2);
      window(40, hi, na, nt);
      check("R4 off source silent", nt, 0);
      task_src = 2'b10;
      tick(2);
      prev = 0; dbl = 0;
      repeat (40) begin
         @(negedge clk);
         if (prev && task_trig) dbl = 1;
         prev = task_trig;
      end
      check("R4 single clock pulse", int'(dbl), 0);

      // R10: period change in mid-cycle
      adc_src = 2'b01; adc_div = 4'd1;
      tick(2);
      do @(negedge clk); while (!adc_trig);
      gap = 0;
      do begin
         @(negedge clk);
         gap++;
         if (gap == 3) per_in = 16'd4;
      end while (!adc_trig);
      check("R10 current cycle keeps old period", gap, 20);
      gap = 0;
      do begin @(negedge clk); gap++; end while (!adc_trig);
      check("R10 new period after minimum", gap, 8);

      tick(4);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule